// File: doc/BRIEF.md
# Four-Channel Bridge PWM Steering

This block turns one pulse-width comparison into drive levels for up to four output channels, A through D, laid out as an H-bridge or half-bridge. An external period timer supplies an 8-bit count, a 2-bit fine extension and a period-match strobe. The block compares the 10-bit timer value against a 10-bit duty word and routes the resulting pulse onto the channels chosen by a 2-bit bridge configuration. Channels that the configuration does not use are flagged as not driven, so the surrounding pin logic can hand them back to general-purpose I/O.

A 4-bit mode selector enables the block. Its upper two bits must be `11` for PWM operation, and its lower two bits then set the active level of the channel pairs {A,C} and {B,D}. When the upper bits hold any other value, the block drives nothing. The duty word is double-buffered: software can rewrite it at any time, but the comparator only picks up a new value at the start of a period.

Top module: `pwm_bridge_steer`

## Requirements
- R1: The duty word is `{duty_hi, duty_lo}`, with `duty_hi` as bits 9..2 and `duty_lo` as bits 1..0. It is compared against the timer value `{tmr_cnt, tmr_fine}`, laid out the same way.
- R2: `period_match` marks the cycle in which the timer shows zero. In that cycle the pulse turns active if the newly loaded duty is nonzero. In each later cycle, the pulse turns inactive once the timer value is greater than or equal to the loaded duty. For a duty D below the period length P (in timer counts), the pulse is therefore active for exactly D cycles of each period.
- R3: A duty of zero keeps the pulse inactive for the whole period.
- R4: A duty greater than or equal to the period length keeps the pulse active for the whole period.
- R5: The duty inputs are captured only in a `period_match` cycle. A change of the duty inputs in the middle of a period has no effect until the next period.
- R6: Bridge configuration `00` (single) drives only channel A (`pin_drive` = `0001`), which carries the pulse. Released channels read level 0.
- R7: Configuration `01` (forward) drives all four channels. D carries the pulse, A is held active, and B and C are held inactive.
- R8: Configuration `10` (half-bridge) drives A and B only (`pin_drive` = `0011`). A carries the pulse and B carries its logical complement.
- R9: Configuration `11` (reverse) drives all four channels. B carries the pulse, C is held active, and A and D are held inactive.
- R10: Polarity comes from `mode_sel[1:0]`. Bit 1 set makes A and C active-low, and bit 0 set makes B and D active-low. A driven pin's level is its logical state XOR its pair's inversion bit.
- R11: When `mode_sel[3:2]` is not `11`, every `pin_drive` and `pin_level` bit reads 0, and the pulse generator is held inactive.
- R12: Outputs are registered. A change of configuration or mode appears on the pins one clock after it is presented. A synchronous active-high reset clears all outputs at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_cnt | input | 8 | Period timer count, duty compare bits 9..2 |
| tmr_fine | input | 2 | Timer fine extension, compare bits 1..0 |
| period_match | input | 1 | High in the first cycle of each period (timer at zero) |
| duty_hi | input | 8 | Duty word bits 9..2 |
| duty_lo | input | 2 | Duty word bits 1..0 |
| mode_sel | input | 4 | [3:2] = `11` enables PWM; [1] inverts A/C; [0] inverts B/D |
| out_cfg | input | 2 | Bridge configuration: 00 single, 01 forward, 10 half, 11 reverse |
| pin_level | output | 4 | Pin levels, bit 0 = A through bit 3 = D |
| pin_drive | output | 4 | Per-pin driven flag, same bit order |

## Verification
The bench measures the active time of the modulated channel over whole periods at duties of 0, 1, exactly the period and far beyond it. A comparator that used equality or was off by one would be a cycle short, would never release, or would emit a one-cycle spike at zero duty. The bench also rewrites the duty mid-period; a design that loaded the duty continuously would cut that period short at the new value. Each bridge configuration is run under opposite polarity codes, so that swapped pairs, a wrong static-active pin or a half-bridge pair left non-complementary show up as wrong static levels or wrong counts. The bench also leaves PWM mode and resets in the middle of a pulse, which catches outputs that go stale or lag by the wrong number of clocks.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;
  localparam int NCH = 4;
  localparam logic [1:0] MODE_PWM = 2'b11;

  typedef enum logic [1:0] {
    CFG_SINGLE = 2'b00,
    CFG_FWD    = 2'b01,
    CFG_HALF   = 2'b10,
    CFG_REV    = 2'b11
  } bridge_cfg_e;
endpackage

// File: rtl/pwm_duty_gen.sv
module pwm_duty_gen
  #(parameter int TMR_W  = 8,
    parameter int FINE_W = 2)
  (input  logic              clk,
   input  logic              rst,
   input  logic              enable,
   input  logic              period_match,
   input  logic [TMR_W-1:0]  tmr_cnt,
   input  logic [FINE_W-1:0] tmr_fine,
   input  logic [TMR_W-1:0]  duty_hi,
   input  logic [FINE_W-1:0] duty_lo,
   output logic              mod_raw);

  localparam int DW = TMR_W + FINE_W;

  logic [DW-1:0] duty_shadow;
  logic [DW-1:0] tnow;
  logic [DW-1:0] duty_next;
  logic          reached;

  assign tnow      = {tmr_cnt, tmr_fine};
  assign duty_next = {duty_hi, duty_lo};
  assign reached   = (tnow >= duty_shadow);

  // shadow duty: loaded only at the period boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      duty_shadow <= '0;
    end else if (period_match) begin
      duty_shadow <= duty_next;
    end
  end

  // pulse: set at period start (unless zero duty), cleared once timer reaches duty
  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      mod_raw <= 1'b0;
    end else if (period_match) begin
      mod_raw <= (duty_next != '0);
    end else if (reached) begin
      mod_raw <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_steer_matrix.sv
module pwm_steer_matrix
  import pwm_steer_pkg::*;
  (input  bridge_cfg_e    cfg,
   input  logic           pwm_on,
   input  logic           mod_raw,
   input  logic [1:0]     pol,
   output logic [NCH-1:0] level,
   output logic [NCH-1:0] drive);

  logic [NCH-1:0] logical;

  // logical (active = 1) state and drive mask per bridge configuration
  always_comb begin
    logical = '0;
    drive   = '0;
    if (pwm_on) begin
      unique case (cfg)
        CFG_SINGLE: begin
          drive   = 4'b0001;
          logical = {3'b000, mod_raw};
        end
        CFG_FWD: begin
          drive   = 4'b1111;
          logical = {mod_raw, 1'b0, 1'b0, 1'b1};
        end
        CFG_HALF: begin
          drive   = 4'b0011;
          logical = {2'b00, ~mod_raw, mod_raw};
        end
        CFG_REV: begin
          drive   = 4'b1111;
          logical = {1'b0, 1'b1, mod_raw, 1'b0};
        end
        default: begin
          drive   = '0;
          logical = '0;
        end
      endcase
    end
  end

  // per-channel polarity: even channels (A,C) use pol[1], odd (B,D) use pol[0]
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int PAIR = i % 2;
    logic inv_c;
    assign inv_c    = (PAIR == 0) ? pol[1] : pol[0];
    assign level[i] = drive[i] & (logical[i] ^ inv_c);
  end
endmodule

// File: rtl/pwm_bridge_steer.sv
module pwm_bridge_steer
  import pwm_steer_pkg::*;
  #(parameter int TMR_W  = 8,
    parameter int FINE_W = 2)
  (input  logic              clk,
   input  logic              rst,
   input  logic [TMR_W-1:0]  tmr_cnt,
   input  logic [FINE_W-1:0] tmr_fine,
   input  logic              period_match,
   input  logic [TMR_W-1:0]  duty_hi,
   input  logic [FINE_W-1:0] duty_lo,
   input  logic [3:0]        mode_sel,
   input  logic [1:0]        out_cfg,
   output logic [3:0]        pin_level,
   output logic [3:0]        pin_drive);

  logic           pwm_on;
  logic           mod_raw;
  logic [NCH-1:0] lvl_c;
  logic [NCH-1:0] drv_c;

  assign pwm_on = (mode_sel[3:2] == MODE_PWM);

  pwm_duty_gen #(.TMR_W(TMR_W), .FINE_W(FINE_W)) u_gen (
    .clk          (clk),
    .rst          (rst),
    .enable       (pwm_on),
    .period_match (period_match),
    .tmr_cnt      (tmr_cnt),
    .tmr_fine     (tmr_fine),
    .duty_hi      (duty_hi),
    .duty_lo      (duty_lo),
    .mod_raw      (mod_raw));

  pwm_steer_matrix u_mtx (
    .cfg     (bridge_cfg_e'(out_cfg)),
    .pwm_on  (pwm_on),
    .mod_raw (mod_raw),
    .pol     (mode_sel[1:0]),
    .level   (lvl_c),
    .drive   (drv_c));

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_level <= '0;
      pin_drive <= '0;
    end else begin
      pin_level <= lvl_c;
      pin_drive <= drv_c;
    end
  end
endmodule

// File: rtl/pwm_bridge_steer_chk.sv
module pwm_bridge_steer_chk
  (input logic       clk,
   input logic       rst,
   input logic [3:0] mode_sel,
   input logic [1:0] out_cfg,
   input logic [3:0] pin_level,
   input logic [3:0] pin_drive);

  logic pwm_on;
  assign pwm_on = (mode_sel[3:2] == 2'b11);

  p_reset_r12: assert property (@(posedge clk)
    rst |=> (pin_drive == 4'b0000 && pin_level == 4'b0000));

  p_release_r11: assert property (@(posedge clk) disable iff (rst)
    !pwm_on |=> (pin_drive == 4'b0000 && pin_level == 4'b0000));

  p_single_r6: assert property (@(posedge clk) disable iff (rst)
    (pwm_on && out_cfg == 2'b00) |=>
      (pin_drive == 4'b0001 && pin_level[3:1] == 3'b000));

  p_fwd_r7: assert property (@(posedge clk) disable iff (rst)
    (pwm_on && out_cfg == 2'b01) |=>
      (pin_drive == 4'b1111 &&
       pin_level[0] == !$past(mode_sel[1]) &&
       pin_level[1] == $past(mode_sel[0]) &&
       pin_level[2] == $past(mode_sel[1])));

  p_half_r8: assert property (@(posedge clk) disable iff (rst)
    (pwm_on && out_cfg == 2'b10) |=>
      (pin_drive == 4'b0011 && pin_level[3:2] == 2'b00 &&
       (pin_level[0] ^ pin_level[1]) == !($past(mode_sel[1]) ^ $past(mode_sel[0]))));

  p_rev_r9: assert property (@(posedge clk) disable iff (rst)
    (pwm_on && out_cfg == 2'b11) |=>
      (pin_drive == 4'b1111 &&
       pin_level[0] == $past(mode_sel[1]) &&
       pin_level[2] == !$past(mode_sel[1]) &&
       pin_level[3] == $past(mode_sel[0])));
endmodule

bind pwm_bridge_steer pwm_bridge_steer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .mode_sel  (mode_sel),
  .out_cfg   (out_cfg),
  .pin_level (pin_level),
  .pin_drive (pin_drive));

// File: tb/pwm_bridge_steer_test.sv
module pwm_bridge_steer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] tmr_cnt = '0;
  logic [1:0] tmr_fine = '0;
  logic       period_match = 1'b0;
  logic [7:0] duty_hi = '0;
  logic [1:0] duty_lo = '0;
  logic [3:0] mode_sel = 4'b1100;
  logic [1:0] out_cfg = 2'b00;
  logic [3:0] pin_level;
  logic [3:0] pin_drive;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwm_bridge_steer uut (
    .clk(clk), .rst(rst), .tmr_cnt(tmr_cnt), .tmr_fine(tmr_fine),
    .period_match(period_match), .duty_hi(duty_hi), .duty_lo(duty_lo),
    .mode_sel(mode_sel), .out_cfg(out_cfg),
    .pin_level(pin_level), .pin_drive(pin_drive));

  typedef struct packed {
    logic [3:0] mode;
    logic [1:0] cfg;
    logic [9:0] duty;
    logic [9:0] per;
    logic [1:0] idx;
    logic [9:0] cnt;
    logic [3:0] drive;
  } row_t;

  localparam int NROW = 14;
  localparam row_t TBL [NROW] = '{
    '{4'b1100, 2'b00, 10'd10,  10'd32, 2'd0, 10'd10, 4'b0001}, // R6 R1 R2
    '{4'b1111, 2'b00, 10'd10,  10'd32, 2'd0, 10'd10, 4'b0001}, // R6 R10
    '{4'b1100, 2'b01, 10'd7,   10'd20, 2'd3, 10'd7,  4'b1111}, // R7 R1
    '{4'b1101, 2'b01, 10'd7,   10'd20, 2'd3, 10'd7,  4'b1111}, // R7 R10
    '{4'b1100, 2'b11, 10'd12,  10'd20, 2'd1, 10'd12, 4'b1111}, // R9
    '{4'b1110, 2'b11, 10'd12,  10'd20, 2'd1, 10'd12, 4'b1111}, // R9 R10
    '{4'b1100, 2'b10, 10'd5,   10'd16, 2'd0, 10'd5,  4'b0011}, // R8
    '{4'b1111, 2'b10, 10'd5,   10'd16, 2'd0, 10'd5,  4'b0011}, // R8 R10
    '{4'b1100, 2'b00, 10'd0,   10'd16, 2'd0, 10'd0,  4'b0001}, // R3
    '{4'b1100, 2'b00, 10'd600, 10'd32, 2'd0, 10'd32, 4'b0001}, // R4
    '{4'b1100, 2'b00, 10'd32,  10'd32, 2'd0, 10'd32, 4'b0001}, // R4 boundary
    '{4'b1100, 2'b00, 10'd1,   10'd16, 2'd0, 10'd1,  4'b0001}, // R2 minimum
    '{4'b0101, 2'b01, 10'd10,  10'd16, 2'd0, 10'd0,  4'b0000}, // R11
    '{4'b1000, 2'b10, 10'd10,  10'd16, 2'd0, 10'd0,  4'b0000}  // R11
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one timer cycle at a negedge, return at the following negedge
  task automatic step(input bit match, input int t);
    period_match = match;
    {tmr_cnt, tmr_fine} = 10'(t);
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic string tag_of(input row_t r);
    if (r.mode[3:2] != 2'b11) return "R11";
    case (r.cfg)
      2'b00:   return "R6";
      2'b01:   return "R7";
      2'b10:   return "R8";
      default: return "R9";
    endcase
  endfunction

  // expected static pins from R7/R9/R10/R11: {mask, levels}
  function automatic logic [7:0] static_exp(input row_t r);
    logic [3:0] m, lg, inv;
    inv = {r.mode[0], r.mode[1], r.mode[0], r.mode[1]};
    m = 4'b0000; lg = 4'b0000;
    if (r.mode[3:2] != 2'b11) return {4'b1111, 4'b0000};
    if (r.cfg == 2'b01) begin m = 4'b0111; lg = 4'b0001; end
    if (r.cfg == 2'b11) begin m = 4'b1101; lg = 4'b0100; end
    if (r.cfg == 2'b00) m = 4'b1110;
    if (r.cfg == 2'b10) m = 4'b1100;
    return {m, (lg ^ inv) & m & r.drive};
  endfunction

  task automatic run_row(input row_t r);
    int hi = 0, e_drv = 0, e_st = 0, e_cmp = 0;
    logic [7:0] se;
    logic act;
    bit pwm;
    pwm = (r.mode[3:2] == 2'b11);
    act = !pwm ? 1'b1 : ((r.idx[0] == 1'b0) ? !r.mode[1] : !r.mode[0]);
    se = static_exp(r);
    mode_sel = r.mode;
    out_cfg = r.cfg;
    {duty_hi, duty_lo} = r.duty;
    for (int k = 0; k <= int'(r.per); k++) begin
      if (k < int'(r.per)) step(k == 0, k);
      else step(1'b1, 0);
      if (k > 0 || k == int'(r.per)) begin
        if (pin_drive != r.drive) e_drv++;
        if ((pin_level & se[7:4]) != se[3:0]) e_st++;
        if (pin_level[r.idx] == act) hi++;
        if (pwm && r.cfg == 2'b10 &&
            ((pin_level[0] ^ pin_level[1]) != !(r.mode[1] ^ r.mode[0]))) e_cmp++;
      end
    end
    check(e_drv == 0, {tag_of(r), " drive mask"}, e_drv, 0);
    check(e_st == 0, {tag_of(r), "/R10 static levels"}, e_st, 0);
    check(hi == int'(r.cnt), {tag_of(r), "/R2 active cycles"}, hi, int'(r.cnt));
    if (pwm && r.cfg == 2'b10) check(e_cmp == 0, "R8 complement", e_cmp, 0);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int hi;
    // R12: outputs cleared while reset is held, even with PWM configured
    duty_hi = 8'd4;
    mode_sel = 4'b1101;
    out_cfg = 2'b01;
    @(negedge clk);
    step(1'b1, 0);
    step(1'b0, 1);
    check(pin_drive == 4'b0000, "R12 reset drive", pin_drive, 0);
    check(pin_level == 4'b0000, "R12 reset level", pin_level, 0);
    rst = 1'b0;

    // vector table walk
    for (int i = 0; i < NROW; i++) run_row(TBL[i]);

    // R5: duty rewritten mid-period takes effect only in the next period
    mode_sel = 4'b1100;
    out_cfg = 2'b00;
    {duty_hi, duty_lo} = 10'd20;
    hi = 0;
    for (int k = 0; k <= 40; k++) begin
      if (k < 40) step(k == 0, k); else step(1'b1, 0);
      if (k == 5) {duty_hi, duty_lo} = 10'd3;
      if (k > 0 && pin_level[0]) hi++;
    end
    check(hi == 20, "R5 old duty kept for period", hi, 20);
    hi = 0;
    for (int k = 1; k <= 40; k++) begin
      if (k < 40) step(1'b0, k); else step(1'b1, 0);
      if (pin_level[0]) hi++;
    end
    check(hi == 3, "R5 new duty next period", hi, 3);

    // R12: leaving PWM mode shows one clock later
    {duty_hi, duty_lo} = 10'd30;
    step(1'b1, 0);
    step(1'b0, 1);
    check(pin_drive == 4'b0001 && pin_level[0], "R12 active before mode change",
          {pin_drive, pin_level}, 8'h11);
    mode_sel = 4'b0000;
    check(pin_drive == 4'b0001, "R12 no change before edge", pin_drive, 1);
    step(1'b0, 2);
    check(pin_drive == 4'b0000 && pin_level == 4'b0000, "R11 released after edge",
          {pin_drive, pin_level}, 0);

    // R12: synchronous reset mid-pulse clears outputs at the next edge
    mode_sel = 4'b1100;
    step(1'b1, 0);
    step(1'b0, 1);
    check(pin_level[0] == 1'b1, "R2 pulse active before reset", pin_level[0], 1);
    rst = 1'b1;
    step(1'b0, 2);
    check(pin_drive == 4'b0000 && pin_level == 4'b0000, "R12 mid-pulse reset",
          {pin_drive, pin_level}, 0);
    rst = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule